// File: doc/BRIEF.md
# One-time-programmable wiper controller with serial bus slave

The block is a two-wire serial (I2C) slave that owns the 6-bit code of a 64-step resistor array. The code starts at midscale. A master can load it, return it to midscale, put the array into shutdown, and read it back together with a 2-bit lock status. SCL and SDA reach the block already synchronised to its system clock. The block only pulls SDA low and never stretches the clock.

After trimming, the master sends a freeze command. The block fires a fixed-length strobe at an external fuse and samples the fuse's pass/fail answer when the strobe ends. From the freeze onward the wiper code cannot be changed. Shutdown stays under bus control after the freeze.

Top module: `otp_wiper_ctrl`

## Requirements
- R1: After reset the wiper code is 0x20, shutdown is low, the fuse strobe is low, SDA is released and the lock status reads 00.
- R2: The slave acknowledges only the address byte 0,1,0,1,1,0,`addr_pin_i`,R/W (MSB first). Any other address gets no acknowledge and changes nothing.
- R3: A write is three acknowledged bytes: address with R/W=0, instruction, then data. When the data byte is complete, data bits 5..0 become the wiper code and data bits 7..6 are ignored.
- R4: Instruction bit 6 (midscale) loads 0x20 in place of the data byte.
- R5: Every complete write sets `shutdown_o` to instruction bit 5. The shutdown flag by itself never alters the wiper code.
- R6: A read is the address byte with R/W=1 followed by one byte the slave drives MSB first: lock status in bits 7..6 and the wiper code in bits 5..0. The slave releases SDA for the master's acknowledge bit.
- R7: Instruction bit 7 (freeze) with status 00 and no programming in progress raises `fuse_prog_o` for exactly PROG_CYCLES clocks and freezes the current code. Freeze overrides bit 6 and the data byte.
- R8: `fuse_ok_i` is sampled in the last cycle of the strobe. The status becomes 10 if it is high and 11 if it is low. Status 01 never appears, and a non-zero status never returns to 00 before reset.
- R9: From the freeze onward, data loads and midscale have no effect on the wiper code, but they are still acknowledged. A second freeze is acknowledged and produces no strobe. Shutdown still follows bit 5.
- R10: A START or STOP in the middle of a byte abandons the transfer with no change. A repeated START begins a new transfer at once.
- R11: A write that stops after the instruction byte changes nothing.
- R12: SDA is released in the clock after a STOP is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA line level |
| addr_pin_i | input | 1 | Strapped low address bit |
| fuse_ok_i | input | 1 | Fuse result, sampled at the end of the strobe |
| sda_drive_o | output | 1 | 1 pulls SDA low |
| wiper_o | output | 6 | Wiper code |
| shutdown_o | output | 1 | Shutdown request to the resistor array |
| fuse_prog_o | output | 1 | Fuse programming strobe |

## Verification
On every cycle the assertions check four things. The wiper holds still whenever it is locked, and it moves only in the cycle after a completed write. The status never takes the unused code and never falls back to blank, and the strobe has the exact PROG_CYCLES width. SDA is released after a STOP, and the strobe can only start from a blank status after a write. The bench's scenarios cover what the assertions cannot see: address matching against the strapped pin, acknowledge placement, the flag priorities inside one instruction byte, the contents of the read-back byte, and transfers abandoned by a STOP or a repeated START.

// File: rtl/otp_wiper_pkg.sv
package otp_wiper_pkg;
  localparam int BYTE_W  = 8;
  localparam int WIPER_W = 6;
  localparam int STAT_W  = BYTE_W - WIPER_W;
  localparam int CNT_W   = 4;

  localparam logic [5:0]         ADDR_HI  = 6'b010110;
  localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);

  // instruction flag positions, also the packing of flags_o
  localparam int FLG_FREEZE = 2;
  localparam int FLG_MID    = 1;
  localparam int FLG_SD     = 0;

  typedef enum logic [STAT_W-1:0] {
    STAT_BLANK = 2'b00,
    STAT_DONE  = 2'b10,
    STAT_BAD   = 2'b11
  } otp_stat_e;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_RX,
    BUS_ACK,
    BUS_TX,
    BUS_MACK
  } bus_st_e;

  typedef enum logic [1:0] {
    FR_ADDR,
    FR_INSTR,
    FR_DATA
  } frame_e;
endpackage

// File: rtl/otp_line_mon.sv
module otp_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  // SDA moving while SCL stays high marks a bus condition
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/otp_frame_fsm.sv
module otp_frame_fsm
  import otp_wiper_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               sda_i,
  input  logic               addr_pin_i,
  input  logic [BYTE_W-1:0]  rd_byte_i,
  output logic               sda_drive_o,
  output logic               wr_stb_o,
  output logic [2:0]         flags_o,
  output logic [WIPER_W-1:0] code_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  bus_st_e           st_q;
  frame_e            fr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              rw_q;
  logic              addr_hit;

  assign addr_hit = (rx_q[BYTE_W-1:1] == {ADDR_HI, addr_pin_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= BUS_IDLE;
      fr_q        <= FR_ADDR;
      cnt_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      rw_q        <= 1'b0;
      sda_drive_o <= 1'b0;
      wr_stb_o    <= 1'b0;
      flags_o     <= '0;
      code_o      <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (start_i) begin
        st_q        <= BUS_RX;
        fr_q        <= FR_ADDR;
        cnt_q       <= '0;
        sda_drive_o <= 1'b0;
      end else if (stop_i) begin
        st_q        <= BUS_IDLE;
        sda_drive_o <= 1'b0;
      end else begin
        unique case (st_q)
          BUS_IDLE: ;
          BUS_RX: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == LAST_BIT) begin
              unique case (fr_q)
                FR_ADDR: begin
                  if (addr_hit) begin
                    rw_q        <= rx_q[0];
                    sda_drive_o <= 1'b1;
                    st_q        <= BUS_ACK;
                  end else begin
                    st_q <= BUS_IDLE;
                  end
                end
                FR_INSTR: begin
                  flags_o     <= rx_q[BYTE_W-1 -: 3];
                  sda_drive_o <= 1'b1;
                  st_q        <= BUS_ACK;
                end
                default: begin
                  code_o      <= rx_q[WIPER_W-1:0];
                  wr_stb_o    <= 1'b1;
                  sda_drive_o <= 1'b1;
                  st_q        <= BUS_ACK;
                end
              endcase
            end
          end
          BUS_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              unique case (fr_q)
                FR_ADDR: begin
                  if (rw_q) begin
                    sda_drive_o <= !rd_byte_i[BYTE_W-1];
                    tx_q        <= {rd_byte_i[BYTE_W-2:0], 1'b0};
                    st_q        <= BUS_TX;
                  end else begin
                    sda_drive_o <= 1'b0;
                    fr_q        <= FR_INSTR;
                    st_q        <= BUS_RX;
                  end
                end
                FR_INSTR: begin
                  sda_drive_o <= 1'b0;
                  fr_q        <= FR_DATA;
                  st_q        <= BUS_RX;
                end
                default: begin
                  sda_drive_o <= 1'b0;
                  st_q        <= BUS_IDLE;
                end
              endcase
            end
          end
          BUS_TX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == LAST_BIT) begin
                sda_drive_o <= 1'b0;
                st_q        <= BUS_MACK;
              end else begin
                sda_drive_o <= !tx_q[BYTE_W-1];
                tx_q        <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          BUS_MACK: begin
            // single-byte read: master's answer closes the transfer
            if (scl_rise_i) st_q <= BUS_IDLE;
          end
          default: st_q <= BUS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_wiper_reg.sv
module otp_wiper_reg
  import otp_wiper_pkg::*;
#(
  parameter int PROG_CYCLES = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_stb_i,
  input  logic [2:0]         flags_i,
  input  logic [WIPER_W-1:0] code_i,
  input  logic               fuse_ok_i,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               shutdown_o,
  output logic               fuse_prog_o,
  output logic [STAT_W-1:0]  stat_o,
  output logic               locked_o,
  output logic [BYTE_W-1:0]  rd_byte_o
);
  localparam int PCNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PROG_CYCLES - 1);

  otp_stat_e         stat_q;
  logic              busy_q;
  logic [PCNT_W-1:0] pcnt_q;

  assign locked_o    = busy_q || (stat_q != STAT_BLANK);
  assign fuse_prog_o = busy_q;
  assign stat_o      = stat_q;
  assign rd_byte_o   = {stat_q, wiper_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_o    <= MIDSCALE;
      shutdown_o <= 1'b0;
      stat_q     <= STAT_BLANK;
      busy_q     <= 1'b0;
      pcnt_q     <= '0;
    end else begin
      if (busy_q) begin
        if (pcnt_q == PCNT_LAST) begin
          busy_q <= 1'b0;
          stat_q <= fuse_ok_i ? STAT_DONE : STAT_BAD;
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
      if (wr_stb_i) begin
        shutdown_o <= flags_i[FLG_SD];
        // priority: freeze, then midscale, then data load
        if (flags_i[FLG_FREEZE]) begin
          if (!locked_o) begin
            busy_q <= 1'b1;
            pcnt_q <= '0;
          end
        end else if (!locked_o) begin
          wiper_o <= flags_i[FLG_MID] ? MIDSCALE : code_i;
        end
      end
    end
  end
endmodule

// File: rtl/otp_wiper_ctrl.sv
module otp_wiper_ctrl
  import otp_wiper_pkg::*;
#(
  parameter int PROG_CYCLES = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_pin_i,
  input  logic       fuse_ok_i,
  output logic       sda_drive_o,
  output logic [5:0] wiper_o,
  output logic       shutdown_o,
  output logic       fuse_prog_o
);
  logic               scl_rise_w, scl_fall_w, start_w, stop_w;
  logic               wr_stb_w, locked_w;
  logic [2:0]         flags_w;
  logic [WIPER_W-1:0] code_w;
  logic [STAT_W-1:0]  stat_w;
  logic [BYTE_W-1:0]  rd_byte_w;

  otp_line_mon u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  otp_frame_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise_w),
    .scl_fall_i  (scl_fall_w),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .sda_i       (sda_i),
    .addr_pin_i  (addr_pin_i),
    .rd_byte_i   (rd_byte_w),
    .sda_drive_o (sda_drive_o),
    .wr_stb_o    (wr_stb_w),
    .flags_o     (flags_w),
    .code_o      (code_w)
  );

  otp_wiper_reg #(.PROG_CYCLES(PROG_CYCLES)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_stb_i    (wr_stb_w),
    .flags_i     (flags_w),
    .code_i      (code_w),
    .fuse_ok_i   (fuse_ok_i),
    .wiper_o     (wiper_o),
    .shutdown_o  (shutdown_o),
    .fuse_prog_o (fuse_prog_o),
    .stat_o      (stat_w),
    .locked_o    (locked_w),
    .rd_byte_o   (rd_byte_w)
  );
endmodule

// File: rtl/otp_wiper_ctrl_chk.sv
module otp_wiper_ctrl_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [5:0] wiper_o,
  input logic       fuse_prog_o,
  input logic       sda_drive_o,
  input logic [1:0] stat_i,
  input logic       locked_i,
  input logic       wr_stb_i,
  input logic       stop_i
);
  int unsigned pw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pw_q <= 0;
    else if (fuse_prog_o) pw_q <= pw_q + 1;
    else pw_q <= 0;
  end

  // R9
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable(wiper_o));

  // R3
  move_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper_o) |-> $past(wr_stb_i));

  // R8
  no_rsvd_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i != 2'b01);

  // R8
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_i) != 2'b00) |-> (stat_i != 2'b00));

  // R7
  strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fuse_prog_o) |-> (pw_q == PROG_CYCLES));

  // R7
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fuse_prog_o) |-> $past(wr_stb_i));

  // R9
  strobe_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fuse_prog_o) |-> (stat_i == 2'b00));

  // R12
  release_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_drive_o);
endmodule

bind otp_wiper_ctrl otp_wiper_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wiper_o     (wiper_o),
  .fuse_prog_o (fuse_prog_o),
  .sda_drive_o (sda_drive_o),
  .stat_i      (stat_w),
  .locked_i    (locked_w),
  .wr_stb_i    (wr_stb_w),
  .stop_i      (stop_w)
);

// File: tb/otp_wiper_ctrl_bench.sv
module otp_wiper_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int PROG       = 20;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1, pin = 1, fuse_ok = 1;
  logic sda_drive, shutdown, fuse_prog;
  logic [5:0] wiper;
  wire  sda_line = sda_m & ~sda_drive;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_wiper_ctrl #(.PROG_CYCLES(PROG)) u_otp_wiper_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_pin_i(pin), .fuse_ok_i(fuse_ok), .sda_drive_o(sda_drive),
    .wiper_o(wiper), .shutdown_o(shutdown), .fuse_prog_o(fuse_prog));

  int checks = 0, fails = 0;
  bit done = 0, settle = 0;

  // behavioural reference state
  logic [5:0] exp_w = 6'h20;
  logic exp_sd = 0, exp_locked = 0;
  logic [1:0] exp_stat = 2'b00;

  int run = 0, last_w = 0, pulses = 0;
  always @(posedge clk) begin
    if (fuse_prog) run <= run + 1;
    else if (run != 0) begin last_w <= run; pulses <= pulses + 1; run <= 0; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !settle && !done) begin
      checks++;
      if (wiper !== exp_w || shutdown !== exp_sd) begin
        fails++;
        $display("FAIL R3/R9 cycle act=%0h/%0b exp=%0h/%0b", wiper, shutdown, exp_w, exp_sd);
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic bus_stop(); sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); endtask
  task automatic bit_out(input logic b); sda_m = b; wq(); scl = 1; wq(); scl = 0; wq(); endtask
  task automatic get_ack(output logic a);
    sda_m = 1; wq(); scl = 1; repeat (2) @(negedge clk); a = sda_line;
    repeat (2) @(negedge clk); scl = 0; wq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    get_ack(a);
  endtask

  function automatic logic [7:0] addr_b(input logic p, input logic rw);
    return {6'b010110, p, rw};
  endfunction

  task automatic model_apply(input logic [7:0] ins, input logic [7:0] dat);
    exp_sd = ins[5];
    if (ins[7]) begin
      if (!exp_locked) exp_locked = 1;
    end else if (!exp_locked) exp_w = ins[6] ? 6'h20 : dat[5:0];
  endtask

  task automatic do_write(input logic p, input logic [7:0] ins, input logic [7:0] dat,
                          output logic a0, output logic a1, output logic a2);
    bus_start();
    send_byte(addr_b(p, 1'b0), a0);
    send_byte(ins, a1);
    settle = 1;
    for (int i = 7; i >= 0; i--) bit_out(dat[i]);
    if (a0 == 0 && a1 == 0) model_apply(ins, dat);
    settle = 0;
    get_ack(a2);
    bus_stop();
  endtask

  task automatic do_read(output logic [7:0] b, output logic a);
    bus_start();
    send_byte(addr_b(pin, 1'b1), a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; wq(); scl = 1; repeat (2) @(negedge clk); b[i] = sda_line;
      repeat (2) @(negedge clk); scl = 0; wq();
    end
    bit_out(1'b1);
    bus_stop();
  endtask

  task automatic read_chk(input string tag);
    logic [7:0] b; logic a;
    do_read(b, a);
    chk(a == 0, {tag, " read ack"}, a, 0);
    chk(b == {exp_stat, exp_w}, {tag, " read byte"}, b, {exp_stat, exp_w});
  endtask

  task automatic wr_chk(input logic [7:0] ins, input logic [7:0] dat, input string tag);
    logic a0, a1, a2;
    do_write(pin, ins, dat, a0, a1, a2);
    chk({a0, a1, a2} == 3'b000, {tag, " acks"}, {a0, a1, a2}, 0);
  endtask

  task automatic do_reset();
    rst_n = 0; scl = 1; sda_m = 1;
    exp_w = 6'h20; exp_sd = 0; exp_locked = 0; exp_stat = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic freeze_chk(input logic [7:0] ins, input logic [7:0] dat, input logic ok, input string tag);
    int p0;
    p0 = pulses;
    fuse_ok = ok;
    wr_chk(ins, dat, tag);
    repeat (PROG + 10) @(negedge clk);
    chk(pulses == p0 + 1, {tag, " R7 one strobe"}, pulses - p0, 1);
    chk(last_w == PROG, {tag, " R7 strobe width"}, last_w, PROG);
    exp_stat = ok ? 2'b10 : 2'b11;
    read_chk({tag, " R8"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] b;
    int p0;
    do_reset();
    // R1
    chk(wiper == 6'h20, "R1 wiper", wiper, 6'h20);
    chk(shutdown == 0 && fuse_prog == 0 && sda_drive == 0, "R1 outputs",
        {shutdown, fuse_prog, sda_drive}, 0);
    read_chk("R1 R6 reset status");

    wr_chk(8'h00, 8'hC5, "R3 load");
    chk(wiper == 6'h05, "R3 upper data bits ignored", wiper, 6'h05);
    read_chk("R3 R6");
    wr_chk(8'h40, 8'h11, "R4 midscale");
    chk(wiper == 6'h20, "R4 midscale beats data", wiper, 6'h20);
    wr_chk(8'h20, 8'h3F, "R5 sd on");
    chk(shutdown == 1 && wiper == 6'h3F, "R5 shutdown set", {shutdown, wiper}, {1'b1, 6'h3F});
    wr_chk(8'h00, 8'h2A, "R5 sd off");
    chk(shutdown == 0, "R5 shutdown clear", shutdown, 0);

    // R2 wrong strapped bit
    do_write(~pin, 8'h00, 8'h01, a0, a1, a2);
    chk(a0 == 1, "R2 foreign address nack", a0, 1);
    chk(wiper == 6'h2A, "R2 no effect", wiper, 6'h2A);
    pin = 0;
    wr_chk(8'h00, 8'h13, "R2 pin low");
    chk(wiper == 6'h13, "R2 pin low load", wiper, 6'h13);

    // R10 STOP mid data byte
    bus_start(); send_byte(addr_b(pin, 0), a0); send_byte(8'h00, a1);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    bus_stop();
    chk(wiper == 6'h13, "R10 stop abort", wiper, 6'h13);
    // R10 repeated START mid instruction byte, then a read
    bus_start(); send_byte(addr_b(pin, 0), a0);
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    do_read(b, a0);
    chk(a0 == 0 && b == {2'b00, 6'h13}, "R10 restart read", b, {2'b00, 6'h13});
    // R11 stop after instruction
    bus_start(); send_byte(addr_b(pin, 0), a0); send_byte(8'h40, a1); bus_stop();
    chk(wiper == 6'h13 && a1 == 0, "R11 no change", wiper, 6'h13);

    // R7 R8 freeze, T beats RS and data
    freeze_chk(8'hC0, 8'h01, 1'b1, "R7 freeze ok");
    chk(wiper == 6'h13, "R7 frozen value", wiper, 6'h13);
    // R9
    wr_chk(8'h00, 8'h00, "R9 load after lock");
    chk(wiper == 6'h13, "R9 load ignored", wiper, 6'h13);
    wr_chk(8'h40, 8'h00, "R9 mid after lock");
    chk(wiper == 6'h13, "R9 mid ignored", wiper, 6'h13);
    wr_chk(8'h20, 8'h00, "R9 sd after lock");
    chk(shutdown == 1, "R9 sd still works", shutdown, 1);
    p0 = pulses;
    wr_chk(8'h80, 8'h00, "R9 second freeze");
    repeat (PROG + 10) @(negedge clk);
    chk(pulses == p0, "R9 no second strobe", pulses - p0, 0);
    read_chk("R9 status kept");

    // R8 failing fuse
    pin = 1;
    do_reset();
    wr_chk(8'h00, 8'h07, "R8 pre");
    freeze_chk(8'h80, 8'h3F, 1'b0, "R8 fuse bad");
    wr_chk(8'h00, 8'h30, "R8 locked after fail");
    chk(wiper == 6'h07, "R8 stays locked", wiper, 6'h07);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule